// File: doc/BRIEF.md
# DDR Read Burst Output Sequencer

This block models the device side of the read path in a double-data-rate synchronous memory. A controller first opens a row in a bank with an activate strobe and then issues read commands, each carrying a bank, a starting column and an auto-precharge flag. The block turns every accepted read into a burst of data elements. The burst starts a programmable number of cycles after the command. The strobe is framed with a preamble before the burst and a postamble on its last element, and the output enables release the bus once the burst is over.

Data is shown at the ports as one pair per clock cycle: the element for the rising half and the element for the falling half. The strobe is high in the rising half of every data cycle and always low in the falling half, so no double-edge clocking is needed inside the block. A newer read can cut short a burst that is still running, or follow it directly, and the data stream keeps going with no gap. The memory core is replaced by a content function: the word at (bank, column) is the zero-extended value {bank, column} XOR the parameter `CORE_SEED` (16'hC3A5 in the bench).

Top module: `ddr_rd_seq`

## Requirements
- R1: With `cfg_cl3`=0 the first data pair is driven 2 cycles after the clock edge that accepts the read. With `cfg_cl3`=1 it is driven 3 cycles after that edge.
- R2: When a burst does not directly follow another, the cycle before its first pair drives the strobe low (`strb_oe`=1, `strb_h`=0) while `q_oe`=0. This is the preamble.
- R3: In every data cycle `q_oe`=1, `strb_oe`=1 and `strb_h`=1. The falling-half element of the last pair is therefore the postamble, with the strobe low. In the cycle after the last pair both `q_oe` and `strb_oe` are 0.
- R4: `cfg_bl` codes 0, 1 and 2 select bursts of 2, 4 and 8 elements, which take 1, 2 and 4 pair cycles.
- R5: With `cfg_ilv`=0 the element k of a burst reads column base | ((start+k) mod BL). Here base is the starting column with its low log2(BL) bits cleared, and start is those low bits.
- R6: With `cfg_ilv`=1 the element k of a burst reads column base | (start XOR k).
- R7: Each element equals {bank, column} zero-extended to 16 bits XOR `CORE_SEED`. The rising half holds the even element and the falling half holds the odd element.
- R8: A read accepted x cycles after an earlier read keeps x pairs of the earlier burst. The newer burst's first pair follows in the very next cycle, with no preamble.
- R9: A read issued exactly one burst's pair count after the previous read concatenates with it. The data stays continuous, with no idle or preamble cycle between the bursts.
- R10: A read to a bank whose row is not open, or whose row is set to close, raises `rd_err` for exactly the cycle after its command edge. It produces no data and leaves a running burst untouched.
- R11: `act_vld` opens the row of a bank; an activate to an already open bank is ignored. After an auto-precharge burst ends, `pre_vld` pulses for one cycle with `pre_bank`. The pulse comes no earlier than the edge after the burst end and no earlier than `TRAS` edges after the activate. After the pulse the bank is closed.
- R12: After reset, every output enable is low, `rd_err` and `pre_vld` are low, and all banks are closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cl3 | input | 1 | Read latency select: 0 gives 2 cycles, 1 gives 3 cycles |
| cfg_bl | input | 2 | Burst length code: 0 for 2, 1 for 4, 2 for 8 elements |
| cfg_ilv | input | 1 | Burst order: 0 sequential, 1 interleaved |
| act_vld | input | 1 | Row activate strobe |
| act_bank | input | 2 | Bank to activate |
| rd_vld | input | 1 | Read command strobe |
| rd_bank | input | 2 | Bank of the read |
| rd_col | input | 8 | Starting column of the read |
| rd_ap | input | 1 | Auto-precharge after this burst |
| q_rise | output | 16 | Data element for the rising half |
| q_fall | output | 16 | Data element for the falling half |
| q_oe | output | 1 | Data lines driven (0 means high impedance) |
| strb_h | output | 1 | Strobe level in the rising half (the falling half is always low) |
| strb_oe | output | 1 | Strobe driven (0 means high impedance) |
| rd_err | output | 1 | Read to a bank without an open row |
| pre_vld | output | 1 | Auto-precharge starts this cycle |
| pre_bank | output | 2 | Bank being precharged |

## Verification
The assertions check, on every cycle, that a preamble is always followed by data and that data never starts without a preamble or a running burst. They also check that a burst advances one pair per cycle until its last pair or a newer read, that an error only comes from a read, and that a precharged bank is closed. The bench scenarios are the only place that show the exact latency for each setting, the column orders and data values, and the pair counts kept on truncation. They also show the seamless joins, that an errored read leaves the running burst intact, and the exact cycle of the auto-precharge pulse against the row-active time.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

    parameter int DQ_W   = 16;
    parameter int COL_W  = 8;
    parameter int BANK_W = 2;
    parameter int NBANK  = 1 << BANK_W;

    typedef struct packed {
        logic            vld;
        logic [DQ_W-1:0] rise;
        logic [DQ_W-1:0] fall;
    } pair_t;

    // Column of element k within a block aligned to the burst size (mask = BL-1)
    function automatic logic [COL_W-1:0] col_at(input logic [COL_W-1:0] col,
                                                input logic [2:0] mask,
                                                input logic ilv,
                                                input logic [2:0] k);
        logic [2:0] off;
        off = ilv ? ((col[2:0] ^ k) & mask) : ((col[2:0] + k) & mask);
        return (col & ~{{(COL_W-3){1'b0}}, mask}) | {{(COL_W-3){1'b0}}, off};
    endfunction

    // Stand-in for the memory array contents
    function automatic logic [DQ_W-1:0] core_word(input logic [BANK_W-1:0] bank,
                                                  input logic [COL_W-1:0] col,
                                                  input logic [DQ_W-1:0] seed);
        return DQ_W'({bank, col}) ^ seed;
    endfunction

endpackage

// File: rtl/ddr_rd_bank_ctl.sv
module ddr_rd_bank_ctl
    import ddr_rd_pkg::*;
#(
    parameter int TRAS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_vld,
    input  logic [BANK_W-1:0] act_bank,
    input  logic              rd_vld,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic              eng_ap_busy,
    input  logic [BANK_W-1:0] eng_bank,
    input  logic              ap_end,
    output logic              rd_ok,
    output logic              rd_err,
    output logic              pre_vld,
    output logic [BANK_W-1:0] pre_bank
);
    localparam int RAS_W = (TRAS > 2) ? $clog2(TRAS) : 1;
    localparam logic [RAS_W-1:0] RAS_MAX = RAS_W'(TRAS - 1);

    typedef struct packed {
        logic [NBANK-1:0]            open;
        logic [NBANK-1:0]            pend;
        logic [NBANK-1:0][RAS_W-1:0] ras;
        logic                        err;
        logic                        pre_vld;
        logic [BANK_W-1:0]           pre_bank;
    } bank_st_t;

    bank_st_t q, d;

    assign rd_ok = q.open[rd_bank] && !q.pend[rd_bank] &&
                   !(eng_ap_busy && (eng_bank == rd_bank));

    always_comb begin
        logic found;
        d         = q;
        d.err     = rd_vld && !rd_ok;
        d.pre_vld = 1'b0;
        found     = 1'b0;
        for (int b = 0; b < NBANK; b++) begin
            if (q.ras[b] != RAS_MAX) d.ras[b] = q.ras[b] + RAS_W'(1);
        end
        if (ap_end) d.pend[eng_bank] = 1'b1;
        for (int b = 0; b < NBANK; b++) begin
            if (!found && q.pend[b] && (q.ras[b] == RAS_MAX)) begin
                found      = 1'b1;
                d.pend[b]  = 1'b0;
                d.open[b]  = 1'b0;
                d.pre_vld  = 1'b1;
                d.pre_bank = BANK_W'(b);
            end
        end
        if (act_vld && !q.open[act_bank]) begin
            d.open[act_bank] = 1'b1;
            d.ras[act_bank]  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_err   = q.err;
    assign pre_vld  = q.pre_vld;
    assign pre_bank = q.pre_bank;

    assert_err_from_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |-> $past(rd_vld));

    assert_precharge_closes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.pre_vld |-> !q.open[q.pre_bank]);

endmodule

// File: rtl/ddr_rd_burst_gen.sv
module ddr_rd_burst_gen
    import ddr_rd_pkg::*;
#(
    parameter logic [DQ_W-1:0] CORE_SEED = 16'hC3A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    input  logic              rd_ap,
    input  logic [1:0]        bl_code,
    input  logic              ilv,
    output pair_t             pair,
    output logic              ap_busy,
    output logic [BANK_W-1:0] cur_bank,
    output logic              ap_end
);
    typedef struct packed {
        logic              vld;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic              ap;
        logic              ilv;
        logic [1:0]        last;
        logic [1:0]        cnt;
    } eng_t;

    eng_t q, d;
    logic is_last;
    logic [2:0] mask;

    assign is_last = (q.cnt == q.last);
    assign mask    = {q.last, 1'b1};

    always_comb begin
        d = q;
        if (q.vld) begin
            if (is_last) d.vld = 1'b0;
            else         d.cnt = q.cnt + 2'd1;
        end
        if (rd_go) begin
            d.vld  = 1'b1;
            d.bank = rd_bank;
            d.col  = rd_col;
            d.ap   = rd_ap;
            d.ilv  = ilv;
            d.cnt  = 2'd0;
            case (bl_code)
                2'd0:    d.last = 2'd0;
                2'd1:    d.last = 2'd1;
                default: d.last = 2'd3;
            endcase
        end
        ap_end = q.vld && q.ap && (is_last || rd_go);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pair.vld  = q.vld;
    assign pair.rise = core_word(q.bank, col_at(q.col, mask, q.ilv, {q.cnt, 1'b0}), CORE_SEED);
    assign pair.fall = core_word(q.bank, col_at(q.col, mask, q.ilv, {q.cnt, 1'b1}), CORE_SEED);
    assign ap_busy   = q.vld && q.ap;
    assign cur_bank  = q.bank;

    assert_pair_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.vld && !is_last && !rd_go) |=> (q.vld && (q.cnt == $past(q.cnt) + 2'd1)));

endmodule

// File: rtl/ddr_rd_out_pipe.sv
module ddr_rd_out_pipe
    import ddr_rd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cl3,
    input  pair_t           in_pair,
    output logic [DQ_W-1:0] q_rise,
    output logic [DQ_W-1:0] q_fall,
    output logic            q_oe,
    output logic            strb_h,
    output logic            strb_oe
);
    typedef struct packed {
        pair_t s1;
        pair_t s2;
        pair_t o;
        logic  pre;
    } pipe_t;

    pipe_t q, d;

    always_comb begin
        d    = q;
        d.s1 = in_pair;
        d.s2 = q.s1;
        d.o  = cl3 ? q.s2 : q.s1;
        // the pair that reaches the output next cycle is d.s1 (CL2) or d.s2 (CL3)
        d.pre = cl3 ? (!q.s2.vld && q.s1.vld) : (!q.s1.vld && in_pair.vld);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign q_rise  = q.o.rise;
    assign q_fall  = q.o.fall;
    assign q_oe    = q.o.vld;
    assign strb_h  = q.o.vld;
    assign strb_oe = q.o.vld || q.pre;

    assert_preamble_then_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_oe && !q_oe) |=> q_oe);

    assert_first_data_after_preamble_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_oe) |-> $past(q.pre));

endmodule

// File: rtl/ddr_rd_seq.sv
module ddr_rd_seq
    import ddr_rd_pkg::*;
#(
    parameter int              TRAS      = 12,
    parameter logic [DQ_W-1:0] CORE_SEED = 16'hC3A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cl3,
    input  logic [1:0]        cfg_bl,
    input  logic              cfg_ilv,
    input  logic              act_vld,
    input  logic [BANK_W-1:0] act_bank,
    input  logic              rd_vld,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    input  logic              rd_ap,
    output logic [DQ_W-1:0]   q_rise,
    output logic [DQ_W-1:0]   q_fall,
    output logic              q_oe,
    output logic              strb_h,
    output logic              strb_oe,
    output logic              rd_err,
    output logic              pre_vld,
    output logic [BANK_W-1:0] pre_bank
);
    logic              rd_ok, rd_go, ap_busy, ap_end;
    logic [BANK_W-1:0] cur_bank;
    pair_t             pair;

    assign rd_go = rd_vld && rd_ok;

    ddr_rd_bank_ctl #(.TRAS(TRAS)) i_bank_ctl (
        .clk(clk), .rst_n(rst_n),
        .act_vld(act_vld), .act_bank(act_bank),
        .rd_vld(rd_vld), .rd_bank(rd_bank),
        .eng_ap_busy(ap_busy), .eng_bank(cur_bank), .ap_end(ap_end),
        .rd_ok(rd_ok), .rd_err(rd_err),
        .pre_vld(pre_vld), .pre_bank(pre_bank)
    );

    ddr_rd_burst_gen #(.CORE_SEED(CORE_SEED)) i_burst_gen (
        .clk(clk), .rst_n(rst_n),
        .rd_go(rd_go), .rd_bank(rd_bank), .rd_col(rd_col), .rd_ap(rd_ap),
        .bl_code(cfg_bl), .ilv(cfg_ilv),
        .pair(pair), .ap_busy(ap_busy), .cur_bank(cur_bank), .ap_end(ap_end)
    );

    ddr_rd_out_pipe i_out_pipe (
        .clk(clk), .rst_n(rst_n), .cl3(cfg_cl3), .in_pair(pair),
        .q_rise(q_rise), .q_fall(q_fall), .q_oe(q_oe),
        .strb_h(strb_h), .strb_oe(strb_oe)
    );

endmodule

// File: tb/test_ddr_rd_seq.sv
module test_ddr_rd_seq;
    localparam logic [15:0] SEED = 16'hC3A5;
    localparam int TRAS = 12;

    logic clk = 0, rst_n = 0;
    logic cfg_cl3 = 0, cfg_ilv = 0, act_vld = 0, rd_vld = 0, rd_ap = 0;
    logic [1:0] cfg_bl = 0, act_bank = 0, rd_bank = 0, pre_bank;
    logic [7:0] rd_col = 0;
    logic [15:0] q_rise, q_fall;
    logic q_oe, strb_h, strb_oe, rd_err, pre_vld;

    int cyc = 0, nchk = 0, nerr = 0;
    logic [15:0] lg_r [256], lg_f [256];
    logic lg_oe [256], lg_soe [256], lg_sh [256], lg_err [256], lg_pre [256];
    logic [1:0] lg_pb [256];

    ddr_rd_seq #(.TRAS(TRAS), .CORE_SEED(SEED)) i_ddr_rd_seq (.*);

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        lg_r[cyc & 255] = q_rise;  lg_f[cyc & 255] = q_fall;
        lg_oe[cyc & 255] = q_oe;   lg_soe[cyc & 255] = strb_oe;
        lg_sh[cyc & 255] = strb_h; lg_err[cyc & 255] = rd_err;
        lg_pre[cyc & 255] = pre_vld; lg_pb[cyc & 255] = pre_bank;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ecol(input int col, input int bl, input bit ilv, input int k);
        int mask = bl - 1;
        int lo = col & mask;
        int off = ilv ? ((lo ^ k) & mask) : ((lo + k) & mask);
        return 8'((col & ~mask) | off);
    endfunction

    function automatic logic [15:0] ecore(input int bank, input logic [7:0] col);
        return 16'({2'(bank), col}) ^ SEED;
    endfunction

    task automatic chk_pair(input string req, input int t, input int bank, input int col,
                            input int bl, input bit ilv, input int p);
        chk({req, " data enable"}, 32'(lg_oe[t & 255]), 1);
        chk({req, " strobe high"}, 32'(lg_sh[t & 255]), 1);
        chk({req, " rise element"}, 32'(lg_r[t & 255]), 32'(ecore(bank, ecol(col, bl, ilv, 2*p))));
        chk({req, " fall element"}, 32'(lg_f[t & 255]), 32'(ecore(bank, ecol(col, bl, ilv, 2*p+1))));
    endtask

    task automatic chk_idle(input string req, input int t);
        chk({req, " data released"}, 32'(lg_oe[t & 255]), 0);
        chk({req, " strobe released"}, 32'(lg_soe[t & 255]), 0);
    endtask

    task automatic chk_pre(input string req, input int t);
        chk({req, " preamble strobe driven"}, 32'(lg_soe[t & 255]), 1);
        chk({req, " preamble strobe low"}, 32'(lg_sh[t & 255]), 0);
        chk({req, " preamble no data"}, 32'(lg_oe[t & 255]), 0);
    endtask

    task automatic set_mode(input bit cl3, input int bl, input bit ilv);
        cfg_cl3 = cl3; cfg_bl = 2'(bl); cfg_ilv = ilv;
    endtask

    task automatic rd(input int b, input int c, input bit ap, output int t);
        rd_vld = 1; rd_bank = 2'(b); rd_col = 8'(c); rd_ap = ap;
        @(posedge clk); @(negedge clk);
        t = cyc; rd_vld = 0; rd_ap = 0;
    endtask

    task automatic act(input int b, output int t);
        act_vld = 1; act_bank = 2'(b);
        @(posedge clk); @(negedge clk);
        t = cyc; act_vld = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        int t;
        chk("R12 data enable", 32'(q_oe), 0);
        chk("R12 strobe enable", 32'(strb_oe), 0);
        chk("R12 error", 32'(rd_err), 0);
        chk("R12 precharge", 32'(pre_vld), 0);
        rd(0, 'h10, 0, t); idle(4);
        chk("R12 closed bank read error", 32'(lg_err[t & 255]), 1);
        chk_idle("R12 no data", t + 2);
    endtask

    task automatic t_cl2_bl4_seq;
        int t;
        set_mode(0, 1, 0); rd(1, 'h15, 0, t); idle(5);
        chk_idle("R1 before preamble", t);
        chk_pre("R2", t + 1);
        chk_pair("R1/R5/R7 pair0", t + 2, 1, 'h15, 4, 0, 0);
        chk_pair("R3/R5/R7 pair1", t + 3, 1, 'h15, 4, 0, 1);
        chk_idle("R3 after burst", t + 4);
    endtask

    task automatic t_cl3_bl8_ilv;
        int t;
        set_mode(1, 2, 1); rd(2, 'h2B, 0, t); idle(8);
        chk_idle("R1 cl3 no early strobe", t + 1);
        chk_pre("R2 cl3", t + 2);
        for (int p = 0; p < 4; p++) chk_pair("R1/R4/R6 interleaved", t + 3 + p, 2, 'h2B, 8, 1, p);
        chk_idle("R3 cl3 after burst", t + 7);
    endtask

    task automatic t_bl2;
        int t;
        set_mode(0, 0, 0); rd(1, 'h09, 0, t); idle(4);
        chk_pre("R2 bl2", t + 1);
        chk_pair("R4/R5 bl2", t + 2, 1, 'h09, 2, 0, 0);
        chk_idle("R4 bl2 single pair", t + 3);
    endtask

    task automatic t_truncate;
        int ta, tb;
        set_mode(0, 2, 0); rd(1, 'h30, 0, ta); rd(2, 'h44, 0, tb); idle(8);
        chk_pre("R8", ta + 1);
        chk_pair("R8 kept pair", ta + 2, 1, 'h30, 8, 0, 0);
        for (int p = 0; p < 4; p++) chk_pair("R8 newer burst", ta + 3 + p, 2, 'h44, 8, 0, p);
        chk_idle("R8 end", ta + 7);
    endtask

    task automatic t_concat;
        int ta, tb;
        set_mode(1, 1, 0); rd(2, 'h06, 0, ta); idle(1); rd(1, 'h21, 0, tb); idle(8);
        chk("R9 issue spacing", 32'(tb - ta), 2);
        chk_pair("R9 first burst p0", ta + 3, 2, 'h06, 4, 0, 0);
        chk_pair("R9 first burst p1", ta + 4, 2, 'h06, 4, 0, 1);
        chk_pair("R9 second burst p0", ta + 5, 1, 'h21, 4, 0, 0);
        chk_pair("R9 second burst p1", ta + 6, 1, 'h21, 4, 0, 1);
        chk_idle("R9 end", ta + 7);
    endtask

    task automatic t_err_midburst;
        int ta, tb;
        set_mode(0, 1, 0); rd(1, 'h50, 0, ta); rd(3, 'h10, 0, tb); idle(6);
        chk("R10 no error for good read", 32'(lg_err[ta & 255]), 0);
        chk("R10 error pulse", 32'(lg_err[tb & 255]), 1);
        chk("R10 error one cycle", 32'(lg_err[(tb + 1) & 255]), 0);
        chk_pair("R10 burst untouched p0", ta + 2, 1, 'h50, 4, 0, 0);
        chk_pair("R10 burst untouched p1", ta + 3, 1, 'h50, 4, 0, 1);
        chk_idle("R10 no data for bad read", ta + 4);
    endtask

    task automatic t_ap_tras;
        int ta, tr, te, tz;
        set_mode(0, 0, 0); act(0, ta); rd(0, 'h12, 1, tr); rd(0, 'h13, 0, te); idle(14);
        chk_pair("R11 ap burst data", tr + 2, 0, 'h12, 2, 0, 0);
        chk("R11 read while closing errs", 32'(lg_err[te & 255]), 1);
        chk("R11 no precharge before row time", 32'(lg_pre[(ta + TRAS - 1) & 255]), 0);
        chk("R11 precharge at row time", 32'(lg_pre[(ta + TRAS) & 255]), 1);
        chk("R11 precharge bank", 32'(lg_pb[(ta + TRAS) & 255]), 0);
        chk("R11 precharge one cycle", 32'(lg_pre[(ta + TRAS + 1) & 255]), 0);
        rd(0, 'h12, 0, tz); idle(2);
        chk("R11 bank closed after precharge", 32'(lg_err[tz & 255]), 1);
    endtask

    task automatic t_ap_end;
        int t, tz;
        set_mode(0, 1, 0); rd(1, 'h00, 1, t); idle(5);
        chk("R11 no precharge at burst end edge", 32'(lg_pre[(t + 2) & 255]), 0);
        chk("R11 precharge edge after burst end", 32'(lg_pre[(t + 3) & 255]), 1);
        chk("R11 precharge bank 1", 32'(lg_pb[(t + 3) & 255]), 1);
        rd(1, 'h00, 0, tz); idle(2);
        chk("R11 bank 1 closed", 32'(lg_err[tz & 255]), 1);
    endtask

    initial begin
        int t;
        idle(3); rst_n = 1; idle(1);
        t_reset();
        act(1, t); act(2, t); idle(15);
        t_cl2_bl4_seq();
        t_cl3_bl8_ilv();
        t_bl2();
        t_truncate();
        t_concat();
        t_err_midburst();
        t_ap_tras();
        t_ap_end();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule